// File: doc/BRIEF.md
# Front-end command sequencer

The sequencer turns one filtered trigger stream into two serial command lines that run on the system clock. The front-end line carries three kinds of command, each a fixed bit pattern starting at its own programmable distance in clocks from the trigger. A trigger command is a single high bit. A calibrate command is the pattern 110. A reset command is the pattern 101. The readout line carries the trigger again at an independent latency. Calibrate and reset commands are produced only when their enable bits are set.

Latencies and enables are loaded through a small write port. Two strobe inputs request a reset pattern straight away. Each kind of delayed event keeps a short queue of due times, and each entry is compared against a free-running clock counter, so several triggers can be in flight at once. When two commands want the same line, the pattern already being sent runs to its end. Any other pending command starts on the first free cycle, in a fixed priority order.

Top module: `fe_cmd_seq`

## Requirements
- R1: Reset drives both lines low and clears every latency register and both enables, so a trigger sent before any configuration produces no output on either line.
- R2: With a nonzero front-end trigger latency L (write address 0), a trigger sampled at clock edge k makes fe_line high for exactly the one cycle that follows edge k+L.
- R3: With the calibrate enable (write address 4, bit 0) set when the trigger is sampled, the pattern 1,1,0 appears on fe_line starting after edge k+Lc, where Lc is the calibrate latency (write address 1). With the enable clear, no calibrate pattern appears.
- R4: With the reset enable (write address 4, bit 1) set when the trigger is sampled, the pattern 1,0,1 appears on fe_line starting after edge k+Lr, where Lr is the reset latency (write address 2). With the enable clear, no reset pattern appears.
- R5: With a nonzero readout latency Lo (write address 3), a trigger sampled at edge k makes ro_line high for exactly the one cycle that follows edge k+Lo.
- R6: A soft_fe_rst strobe sampled at edge k, with both lines idle, sends 1,0,1 on fe_line and on ro_line, starting after edge k.
- R7: A soft_ro_rst strobe has the same effect as soft_fe_rst: 1,0,1 on both lines, starting after the sampling edge.
- R8: A pattern that has started on a line always runs to its end. A command that falls due while its line is busy starts on the cycle right after the last bit of the running pattern. If several commands are ready on the same free cycle, they are served in the order trigger, then reset, then calibrate.
- R9: Each event kind holds up to QD (default 4) triggers in flight. A trigger that arrives while that kind's queue is full is dropped for that kind only.
- R10: A latency value of 0 disables its event: triggers schedule nothing for that kind, and the other kinds are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Filtered trigger, one pulse per clock-high sample |
| soft_fe_rst | input | 1 | Front-end soft reset request strobe |
| soft_ro_rst | input | 1 | Readout soft reset request strobe |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration address (0 fe lat, 1 cal lat, 2 rst lat, 3 ro lat, 4 enables) |
| cfg_wdata | input | LAT_W | Configuration write data |
| fe_line | output | 1 | Serial front-end command line |
| ro_line | output | 1 | Serial readout trigger line |

## Verification
The hardest situation to reach is a collision on a line. Here a delayed command falls due while another pattern is still being shifted out, or several kinds fall due on the same cycle and the arbitration order decides the result. The bench reaches it on purpose by choosing latencies so that the due times line up: a calibrate latency one clock shorter than the trigger latency, three equal latencies, and a soft reset that meets a one-clock readout trigger. It fills a queue with a burst of triggers on consecutive clocks so that the fifth trigger is dropped.

// File: rtl/fe_cmd_seq.sv
module fe_cmd_seq #(
  parameter int LAT_W = 16,
  parameter int QD    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             soft_fe_rst,
  input  logic             soft_ro_rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [LAT_W-1:0] cfg_wdata,
  output logic             fe_line,
  output logic             ro_line
);
  localparam int NQ = 4;
  localparam int PW = $clog2(QD);
  localparam logic [PW:0] QFULL = QD[PW:0];
  localparam int Q_FE = 0, Q_CAL = 1, Q_RST = 2, Q_RO = 3;

  logic [LAT_W-1:0] lat_fe, lat_cal, lat_rst, lat_ro;
  logic             cal_en, rst_en;
  logic [LAT_W-1:0] now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_fe <= '0; lat_cal <= '0; lat_rst <= '0; lat_ro <= '0;
      cal_en <= 1'b0; rst_en <= 1'b0;
      now    <= '0;
    end else begin
      now <= now + 1'b1;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: lat_fe  <= cfg_wdata;
          3'd1: lat_cal <= cfg_wdata;
          3'd2: lat_rst <= cfg_wdata;
          3'd3: lat_ro  <= cfg_wdata;
          3'd4: begin cal_en <= cfg_wdata[0]; rst_en <= cfg_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  logic [LAT_W-1:0] lat [NQ];
  logic [NQ-1:0]    push, hit;

  assign lat[Q_FE]  = lat_fe;
  assign lat[Q_CAL] = lat_cal;
  assign lat[Q_RST] = lat_rst;
  assign lat[Q_RO]  = lat_ro;

  assign push[Q_FE]  = trig_in && (lat_fe  != '0);
  assign push[Q_CAL] = trig_in && cal_en && (lat_cal != '0);
  assign push[Q_RST] = trig_in && rst_en && (lat_rst != '0);
  assign push[Q_RO]  = trig_in && (lat_ro  != '0);

  genvar q;
  generate
    for (q = 0; q < NQ; q++) begin : g_q
      logic [LAT_W-1:0] mem [QD];
      logic [PW-1:0]    wp, rp;
      logic [PW:0]      cnt;
      logic             take;

      assign hit[q] = (cnt != '0) && (mem[rp] == now);
      assign take   = push[q] && ((cnt != QFULL) || hit[q]);

      always_ff @(posedge clk) begin
        if (take) mem[wp] <= now + lat[q];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wp <= '0; rp <= '0; cnt <= '0;
        end else begin
          if (take)   wp <= wp + 1'b1;
          if (hit[q]) rp <= rp + 1'b1;
          cnt <= cnt + {{PW{1'b0}}, take} - {{PW{1'b0}}, hit[q]};
        end
      end
    end
  endgenerate

  wire soft_any = soft_fe_rst | soft_ro_rst;

  // front-end line: bit 0 trigger, bit 1 reset, bit 2 calibrate
  logic [2:0] fe_pend, fe_req, fe_go;
  logic [1:0] fe_cnt, fe_sh;
  wire        fe_req_trg = fe_req[0];

  assign fe_req[0] = fe_pend[0] | hit[Q_FE];
  assign fe_req[1] = fe_pend[1] | hit[Q_RST] | soft_any;
  assign fe_req[2] = fe_pend[2] | hit[Q_CAL];

  always_comb begin
    fe_go = 3'b000;
    if (fe_cnt == 2'd0) begin
      if      (fe_req[0]) fe_go = 3'b001;
      else if (fe_req[1]) fe_go = 3'b010;
      else if (fe_req[2]) fe_go = 3'b100;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fe_pend <= '0; fe_cnt <= '0; fe_sh <= '0; fe_line <= 1'b0;
    end else begin
      fe_pend <= fe_req & ~fe_go;
      if (fe_go[0]) begin
        fe_line <= 1'b1; fe_sh <= 2'b00; fe_cnt <= 2'd0;
      end else if (fe_go[1]) begin
        fe_line <= 1'b1; fe_sh <= 2'b01; fe_cnt <= 2'd2;
      end else if (fe_go[2]) begin
        fe_line <= 1'b1; fe_sh <= 2'b10; fe_cnt <= 2'd2;
      end else if (fe_cnt != 2'd0) begin
        fe_line <= fe_sh[1]; fe_sh <= {fe_sh[0], 1'b0}; fe_cnt <= fe_cnt - 2'd1;
      end else begin
        fe_line <= 1'b0;
      end
    end
  end

  // readout line: bit 0 trigger, bit 1 reset
  logic [1:0] ro_pend, ro_req, ro_go;
  logic [1:0] ro_cnt, ro_sh;
  wire        ro_req_trg = ro_req[0];

  assign ro_req[0] = ro_pend[0] | hit[Q_RO];
  assign ro_req[1] = ro_pend[1] | soft_any;

  always_comb begin
    ro_go = 2'b00;
    if (ro_cnt == 2'd0) begin
      if      (ro_req[0]) ro_go = 2'b01;
      else if (ro_req[1]) ro_go = 2'b10;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ro_pend <= '0; ro_cnt <= '0; ro_sh <= '0; ro_line <= 1'b0;
    end else begin
      ro_pend <= ro_req & ~ro_go;
      if (ro_go[0]) begin
        ro_line <= 1'b1; ro_sh <= 2'b00; ro_cnt <= 2'd0;
      end else if (ro_go[1]) begin
        ro_line <= 1'b1; ro_sh <= 2'b01; ro_cnt <= 2'd2;
      end else if (ro_cnt != 2'd0) begin
        ro_line <= ro_sh[1]; ro_sh <= {ro_sh[0], 1'b0}; ro_cnt <= ro_cnt - 2'd1;
      end else begin
        ro_line <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fe_cmd_seq_chk.sv
module fe_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_fe_rst,
  input logic       soft_ro_rst,
  input logic       fe_line,
  input logic       ro_line,
  input logic [1:0] fe_cnt,
  input logic [1:0] fe_sh,
  input logic [1:0] ro_cnt,
  input logic       fe_req_trg,
  input logic       ro_req_trg
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!fe_line && !ro_line));

  a_r3_cal_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_cnt == 2'd2 && fe_sh == 2'b10) |-> fe_line ##1 fe_line ##1 !fe_line);

  a_r4_rst_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_cnt == 2'd2 && fe_sh == 2'b01) |-> fe_line ##1 !fe_line ##1 fe_line);

  a_r6_soft_fe_now: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_fe_rst || soft_ro_rst) && fe_cnt == 2'd0 && !fe_req_trg)
      |=> fe_line ##1 !fe_line ##1 fe_line);

  a_r7_soft_ro_now: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_fe_rst || soft_ro_rst) && ro_cnt == 2'd0 && !ro_req_trg)
      |=> ro_line ##1 !ro_line ##1 ro_line);

  a_r8_fe_no_cutoff: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_cnt != 2'd0) |=> (fe_cnt == $past(fe_cnt) - 2'd1));

  a_r8_ro_no_cutoff: assert property (@(posedge clk) disable iff (!rst_n)
    (ro_cnt != 2'd0) |=> (ro_cnt == $past(ro_cnt) - 2'd1));
endmodule

bind fe_cmd_seq fe_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_fe_rst(soft_fe_rst), .soft_ro_rst(soft_ro_rst),
  .fe_line(fe_line), .ro_line(ro_line), .fe_cnt(fe_cnt), .fe_sh(fe_sh),
  .ro_cnt(ro_cnt), .fe_req_trg(fe_req_trg), .ro_req_trg(ro_req_trg)
);

// File: tb/fe_cmd_seq_test.sv
module fe_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig_in = 1'b0, soft_fe_rst = 1'b0, soft_ro_rst = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        fe_line, ro_line;
  int          total = 0, bad = 0;
  logic [63:0] fe_c, ro_c;

  always #10 clk = ~clk;

  fe_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .soft_fe_rst(soft_fe_rst),
    .soft_ro_rst(soft_ro_rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .fe_line(fe_line), .ro_line(ro_line)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // stimulus bit i is sampled at edge i; capture bit i reflects edge i
  task automatic run(input logic [63:0] tv, input logic [63:0] sfv, input logic [63:0] srv);
    for (int i = 0; i < 64; i++) begin
      trig_in = tv[i]; soft_fe_rst = sfv[i]; soft_ro_rst = srv[i];
      @(negedge clk);
      fe_c[i] = fe_line; ro_c[i] = ro_line;
    end
    trig_in = 1'b0; soft_fe_rst = 1'b0; soft_ro_rst = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 fe low in reset", {63'd0, fe_line}, 64'd0);
    chk("R1 ro low in reset", {63'd0, ro_line}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run(64'd1, 64'd0, 64'd0);
    chk("R1 fe unprogrammed", fe_c, 64'd0);
    chk("R1 ro unprogrammed", ro_c, 64'd0);

    // R2 / R5 latency sweep
    for (int l = 1; l <= 20; l++) begin
      wr(0, l); wr(3, 25 - l);
      run(64'd1, 64'd0, 64'd0);
      chk("R2 fe trigger latency", fe_c, 64'd1 << l);
      chk("R5 ro trigger latency", ro_c, 64'd1 << (25 - l));
    end

    // R3 calibrate sweep
    wr(0, 40); wr(3, 45); wr(4, 1);
    for (int l = 1; l <= 10; l++) begin
      wr(1, l);
      run(64'd1, 64'd0, 64'd0);
      chk("R3 calibrate 110", fe_c, (64'd1 << 40) | (64'd3 << l));
    end

    // R4 reset sweep
    wr(4, 2);
    for (int l = 1; l <= 10; l++) begin
      wr(2, l);
      run(64'd1, 64'd0, 64'd0);
      chk("R4 reset 101", fe_c, (64'd1 << 40) | (64'd5 << l));
    end

    // R3/R4 disabled
    wr(4, 0); wr(1, 5); wr(2, 7);
    run(64'd1, 64'd0, 64'd0);
    chk("R3 R4 enables clear", fe_c, 64'd1 << 40);

    // R10 zero latency
    wr(0, 0);
    run(64'd1, 64'd0, 64'd0);
    chk("R10 fe disabled", fe_c, 64'd0);
    chk("R10 ro unaffected", ro_c, 64'd1 << 45);
    wr(0, 40);

    // R6 / R7 soft requests
    run(64'd0, 64'd1, 64'd0);
    chk("R6 soft fe on fe", fe_c, 64'd5);
    chk("R6 soft fe on ro", ro_c, 64'd5);
    run(64'd0, 64'd0, 64'd1);
    chk("R7 soft ro on fe", fe_c, 64'd5);
    chk("R7 soft ro on ro", ro_c, 64'd5);

    // R8 deferral: calibrate at 1 blocks trigger due at 2
    wr(4, 1); wr(1, 1); wr(0, 2);
    run(64'd1, 64'd0, 64'd0);
    chk("R8 trigger deferred", fe_c, 64'h16);
    // R8 priority: trigger, reset, calibrate all due at 3
    wr(4, 3); wr(1, 3); wr(2, 3); wr(0, 3);
    run(64'd1, 64'd0, 64'd0);
    chk("R8 priority order", fe_c, 64'h1D8);
    // R8 soft reset meets readout trigger due at 1
    wr(4, 0); wr(0, 10); wr(3, 1);
    run(64'd1, 64'd0, 64'd1);
    chk("R8 ro trigger after soft", ro_c, 64'hD);
    chk("R8 fe soft then trigger", fe_c, 64'h405);

    // R9 triggers in flight
    wr(3, 30);
    run(64'h55, 64'd0, 64'd0);
    chk("R9 four in flight fe", fe_c, 64'h55 << 10);
    chk("R9 four in flight ro", ro_c, 64'h55 << 30);
    run(64'h1F, 64'd0, 64'd0);
    chk("R9 fifth dropped fe", fe_c, 64'hF << 10);
    chk("R9 fifth dropped ro", ro_c, 64'hF << 30);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule